// File: doc/BRIEF.md
# Vectored interrupt controller

This block gathers level-sensitive interrupt requests from peripherals and turns them into two processor interrupt lines: a fast one and a normal one. Each source can be raised by hardware or by software, enabled or masked, and routed to either line. All control lives in a small register file reached over a simple 32-bit register bus that carries a privilege flag with each access.

For the normal line the block also hands the handler a jump address. A bank of prioritised vector slots each names a source. The lowest-numbered enabled slot whose source has a pending normal request supplies its stored address. Otherwise a default address is returned. Reading the current-vector register marks that slot as in service, so only slots of higher priority can be presented. A write to the same register ends the service of the highest-priority slot in service.

Top module: `vec_irq_ctrl`

## Requirements
- R1: The raw status register (offset 0x008, read-only) returns the hardware request lines ORed with the software request register, whatever the enable and routing settings.
- R2: The routing register (offset 0x00C, read/write) holds one bit per source; 1 sends the source to the fast line and 0 sends it to the normal line.
- R3: Fast status (0x004) reads raw AND enable AND routing; normal status (0x000) reads raw AND enable AND NOT routing.
- R4: `fastIrq` is the OR of the fast status bits and `normIrq` is the OR of the normal status bits.
- R5: The enable register (0x010) is read/write; each 1 written to 0x014 clears that enable bit, and 0 bits there leave enables unchanged.
- R6: The software request register (0x018) is read/write; each 1 written to 0x01C clears that bit.
- R7: When bit 0 of the protection register (0x020) is 1, a write with `busPriv` low changes no register and a read with `busPriv` low returns zero; privileged accesses are unaffected.
- R8: The default vector register (0x034) is read/write, and a read of 0x030 returns it when no vector slot matches.
- R9: Slot n has an address register at 0x100+4n and a control register at 0x200+4n (bits 4:0 source number, bit 5 slot enable). A read of 0x030 returns the address of the lowest-numbered enabled slot whose source has its normal status bit set; fast-routed sources never match.
- R10: A read of 0x030 that matches slot n puts slot n in service; while slots are in service, only slots numbered below the lowest one in service can match. A write to 0x030 takes the lowest-numbered slot out of service.
- R11: After reset every register reads zero and both interrupt outputs are low.
- R12: Reads of unmapped or unaligned offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hwIrq | input | 32 | Level-sensitive hardware request lines |
| busSel | input | 1 | Register access in this cycle |
| busWr | input | 1 | 1 for write, 0 for read |
| busAddr | input | 12 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busPriv | input | 1 | Access made in privileged mode |
| busRdata | output | 32 | Read data, valid in the cycle of the read |
| fastIrq | output | 1 | Fast interrupt request |
| normIrq | output | 1 | Normal interrupt request |

## Verification
The bench builds the block with its default parameters: 32 sources, 16 vector slots and a 32-bit bus, so a 5-bit source field and bit 5 as slot enable. That brings nested service within reach: a low-priority slot is acknowledged, a higher slot preempts it, and the in-service set is released one level per end-of-service write. Protection is tested from both privilege levels, including an attempt to clear the protection bit itself.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;
  localparam int ADDR_W     = 12;
  localparam int SLOT_IDX_W = 6;

  localparam logic [ADDR_W-1:0] OFS_NORM    = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_FAST    = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_RAW     = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_ROUTE   = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_EN      = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_ENCLR   = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_SOFT    = 12'h018;
  localparam logic [ADDR_W-1:0] OFS_SOFTCLR = 12'h01C;
  localparam logic [ADDR_W-1:0] OFS_PROT    = 12'h020;
  localparam logic [ADDR_W-1:0] OFS_CURVEC  = 12'h030;
  localparam logic [ADDR_W-1:0] OFS_DEFVEC  = 12'h034;
  localparam logic [3:0] PAGE_SLOTADDR = 4'h1;
  localparam logic [3:0] PAGE_SLOTCTRL = 4'h2;

  typedef enum logic [3:0] {
    RD_NONE, RD_NORM, RD_FAST, RD_RAW, RD_ROUTE, RD_EN, RD_SOFT,
    RD_PROT, RD_CURVEC, RD_DEFVEC, RD_SLOTADDR, RD_SLOTCTRL
  } rdSrc_e;

  typedef struct packed {
    logic wrRoute;
    logic wrEn;
    logic wrEnClr;
    logic wrSoft;
    logic wrSoftClr;
    logic wrProt;
    logic wrDefVec;
    logic endSvc;
    logic ackVec;
    logic wrSlotAddr;
    logic wrSlotCtrl;
    logic [SLOT_IDX_W-1:0] slotIdx;
    rdSrc_e rdSrc;
  } strobes_t;
endpackage

// File: rtl/vec_irq_decode.sv
module vec_irq_decode
  import vec_irq_pkg::*;
#(
  parameter int NUM_SLOT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busPriv,
  input  logic              protOn,
  output strobes_t          strb
);
  logic   granted;
  logic   inSlotRange;
  rdSrc_e src;

  always_comb begin
    strb        = '0;
    src         = RD_NONE;
    granted     = busSel && (!protOn || busPriv);
    inSlotRange = (busAddr[1:0] == 2'b00) && (int'(busAddr[7:2]) < NUM_SLOT);
    strb.slotIdx = busAddr[7:2];
    if (granted) begin
      case (busAddr)
        OFS_NORM:    src = RD_NORM;
        OFS_FAST:    src = RD_FAST;
        OFS_RAW:     src = RD_RAW;
        OFS_ROUTE:   begin src = RD_ROUTE;  strb.wrRoute   = busWr; end
        OFS_EN:      begin src = RD_EN;     strb.wrEn      = busWr; end
        OFS_ENCLR:   strb.wrEnClr = busWr;
        OFS_SOFT:    begin src = RD_SOFT;   strb.wrSoft    = busWr; end
        OFS_SOFTCLR: strb.wrSoftClr = busWr;
        OFS_PROT:    begin src = RD_PROT;   strb.wrProt    = busWr; end
        OFS_CURVEC:  begin src = RD_CURVEC; strb.endSvc = busWr; strb.ackVec = !busWr; end
        OFS_DEFVEC:  begin src = RD_DEFVEC; strb.wrDefVec  = busWr; end
        default: begin
          if (inSlotRange && busAddr[11:8] == PAGE_SLOTADDR) begin
            src = RD_SLOTADDR;
            strb.wrSlotAddr = busWr;
          end else if (inSlotRange && busAddr[11:8] == PAGE_SLOTCTRL) begin
            src = RD_SLOTCTRL;
            strb.wrSlotCtrl = busWr;
          end
        end
      endcase
      strb.rdSrc = busWr ? RD_NONE : src;
    end
  end

  // R7: an unprivileged access under protection raises no strobe at all
  assert_refused_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && protOn && !busPriv) |->
      !(strb.wrRoute || strb.wrEn || strb.wrEnClr || strb.wrSoft || strb.wrSoftClr ||
        strb.wrProt || strb.wrDefVec || strb.endSvc || strb.ackVec ||
        strb.wrSlotAddr || strb.wrSlotCtrl));
endmodule

// File: rtl/vec_irq_datapath.sv
module vec_irq_datapath
  import vec_irq_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SLOT = 16,
  parameter int DATA_W   = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] hwIrq,
  input  logic [DATA_W-1:0]  wdata,
  input  strobes_t           strb,
  output logic               protOn,
  output logic [DATA_W-1:0]  rdata,
  output logic               fastIrq,
  output logic               normIrq
);
  localparam int SRC_W  = $clog2(NUM_SRC);
  localparam int SLOT_W = $clog2(NUM_SLOT);

  logic [NUM_SRC-1:0]  routeQ, enQ, softQ;
  logic [NUM_SRC-1:0]  rawStat, fastStat, normStat;
  logic                protQ;
  logic [DATA_W-1:0]   defVecQ;
  logic [DATA_W-1:0]   slotAddrQ [NUM_SLOT];
  logic [SRC_W-1:0]    slotSrcQ  [NUM_SLOT];
  logic [NUM_SLOT-1:0] slotEnQ;
  logic [NUM_SLOT-1:0] inSvcQ;
  logic                hit, blocked;
  logic [SLOT_W-1:0]   hitIdx;
  logic [DATA_W-1:0]   curVec, selSlotAddr, selSlotCtrl;

  assign rawStat  = hwIrq | softQ;
  assign fastStat = rawStat & enQ & routeQ;
  assign normStat = rawStat & enQ & ~routeQ;
  assign fastIrq  = |fastStat;
  assign normIrq  = |normStat;
  assign protOn   = protQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      routeQ <= '0; enQ <= '0; softQ <= '0; protQ <= 1'b0; defVecQ <= '0;
    end else begin
      if (strb.wrRoute)   routeQ  <= wdata[NUM_SRC-1:0];
      if (strb.wrEn)      enQ     <= wdata[NUM_SRC-1:0];
      if (strb.wrEnClr)   enQ     <= enQ & ~wdata[NUM_SRC-1:0];
      if (strb.wrSoft)    softQ   <= wdata[NUM_SRC-1:0];
      if (strb.wrSoftClr) softQ   <= softQ & ~wdata[NUM_SRC-1:0];
      if (strb.wrProt)    protQ   <= wdata[0];
      if (strb.wrDefVec)  defVecQ <= wdata;
    end
  end

  for (genvar g = 0; g < NUM_SLOT; g++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotAddrQ[g] <= '0;
        slotSrcQ[g]  <= '0;
        slotEnQ[g]   <= 1'b0;
      end else begin
        if (strb.wrSlotAddr && strb.slotIdx == SLOT_IDX_W'(g)) slotAddrQ[g] <= wdata;
        if (strb.wrSlotCtrl && strb.slotIdx == SLOT_IDX_W'(g)) begin
          slotSrcQ[g] <= wdata[SRC_W-1:0];
          slotEnQ[g]  <= wdata[SRC_W];
        end
      end
    end
  end

  // Priority search: a slot is blocked once any slot at or above its priority is in service.
  always_comb begin
    hit = 1'b0; hitIdx = '0; blocked = 1'b0;
    for (int n = 0; n < NUM_SLOT; n++) begin
      blocked = blocked | inSvcQ[n];
      if (!hit && !blocked && slotEnQ[n] && normStat[slotSrcQ[n]]) begin
        hit    = 1'b1;
        hitIdx = SLOT_W'(n);
      end
    end
  end
  assign curVec = hit ? slotAddrQ[hitIdx] : defVecQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  inSvcQ <= '0;
    else if (strb.endSvc)       inSvcQ <= inSvcQ & (inSvcQ - NUM_SLOT'(1));
    else if (strb.ackVec && hit) inSvcQ <= inSvcQ | (NUM_SLOT'(1) << hitIdx);
  end

  always_comb begin
    selSlotAddr = '0;
    selSlotCtrl = '0;
    for (int n = 0; n < NUM_SLOT; n++) begin
      if (strb.slotIdx == SLOT_IDX_W'(n)) begin
        selSlotAddr = slotAddrQ[n];
        selSlotCtrl = DATA_W'({slotEnQ[n], slotSrcQ[n]});
      end
    end
  end

  always_comb begin
    case (strb.rdSrc)
      RD_NORM:     rdata = DATA_W'(normStat);
      RD_FAST:     rdata = DATA_W'(fastStat);
      RD_RAW:      rdata = DATA_W'(rawStat);
      RD_ROUTE:    rdata = DATA_W'(routeQ);
      RD_EN:       rdata = DATA_W'(enQ);
      RD_SOFT:     rdata = DATA_W'(softQ);
      RD_PROT:     rdata = DATA_W'(protQ);
      RD_CURVEC:   rdata = curVec;
      RD_DEFVEC:   rdata = defVecQ;
      RD_SLOTADDR: rdata = selSlotAddr;
      RD_SLOTCTRL: rdata = selSlotCtrl;
      default:     rdata = '0;
    endcase
  end

  assert_enable_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEnClr |=> (enQ & $past(wdata[NUM_SRC-1:0])) == '0);
  assert_soft_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrSoftClr |=> (softQ & $past(wdata[NUM_SRC-1:0])) == '0);
  assert_quiet_lines_R4: assert property (@(posedge clk) disable iff (!rstN)
    (enQ == '0) |-> (!fastIrq && !normIrq));
  assert_ack_marks_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ackVec && hit) |=> (inSvcQ != '0));
  assert_eoi_pops_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.endSvc && inSvcQ != '0) |=> ($countones(inSvcQ) == $countones($past(inSvcQ)) - 1));
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vec_irq_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SLOT = 16,
  parameter int DATA_W   = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] hwIrq,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic               busPriv,
  output logic [DATA_W-1:0]  busRdata,
  output logic               fastIrq,
  output logic               normIrq
);
  strobes_t strb;
  logic     protOn;

  vec_irq_decode #(.NUM_SLOT(NUM_SLOT)) uDecode (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busPriv(busPriv), .protOn(protOn), .strb(strb)
  );

  vec_irq_datapath #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .hwIrq(hwIrq), .wdata(busWdata), .strb(strb),
    .protOn(protOn), .rdata(busRdata), .fastIrq(fastIrq), .normIrq(normIrq)
  );

  assert_refused_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && protOn && !busPriv) |-> (busRdata == '0));
  assert_idle_read_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!busSel) |-> (busRdata == '0));
endmodule

// File: tb/tb_vec_irq_ctrl.sv
module tb_vec_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] val;
    logic [3:0]  req;
  } step_t;

  // hwIrq = 0x0000_00F0 and busPriv = 1 throughout the table
  localparam step_t STEPS [17] = '{
    '{1'b1, 12'h010, 32'h0000_00FF, 4'd5},   // R5 enable low byte
    '{1'b1, 12'h00C, 32'h0000_0030, 4'd2},   // R2 sources 4,5 fast
    '{1'b1, 12'h018, 32'h0000_0101, 4'd6},   // R6 software bits 0,8
    '{1'b0, 12'h008, 32'h0000_01F1, 4'd1},   // R1 raw
    '{1'b0, 12'h004, 32'h0000_0030, 4'd3},   // R3 fast status
    '{1'b0, 12'h000, 32'h0000_00C1, 4'd3},   // R3 normal status
    '{1'b0, 12'h00C, 32'h0000_0030, 4'd2},   // R2 readback
    '{1'b1, 12'h014, 32'h0000_0081, 4'd5},   // R5 clear enables 0,7
    '{1'b0, 12'h010, 32'h0000_007E, 4'd5},   // R5 readback
    '{1'b0, 12'h000, 32'h0000_0040, 4'd3},   // R3 normal after clear
    '{1'b1, 12'h01C, 32'h0000_0001, 4'd6},   // R6 clear soft bit 0
    '{1'b0, 12'h018, 32'h0000_0100, 4'd6},   // R6 readback
    '{1'b0, 12'h008, 32'h0000_01F0, 4'd1},   // R1 raw after clear
    '{1'b1, 12'h034, 32'hDEAD_0000, 4'd8},   // R8 default vector
    '{1'b0, 12'h030, 32'hDEAD_0000, 4'd8},   // R8 no slot enabled
    '{1'b0, 12'h040, 32'h0000_0000, 4'd12},  // R12 unmapped
    '{1'b0, 12'h011, 32'h0000_0000, 4'd12}   // R12 unaligned
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] hwIrq = '0;
  logic        busSel = 1'b0, busWr = 1'b0, busPriv = 1'b1;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        fastIrq, normIrq;
  int          total = 0, bad = 0;
  logic        finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_irq_ctrl dut (
    .clk(clk), .rstN(rstN), .hwIrq(hwIrq), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busPriv(busPriv),
    .busRdata(busRdata), .fastIrq(fastIrq), .normIrq(normIrq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d, input logic p);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d; busPriv = p;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; busPriv = 1'b1;
  endtask

  task automatic busRead(input logic [11:0] a, input logic p, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a; busPriv = p;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 1'b0; busPriv = 1'b1;
  endtask

  task automatic readCheck(input string req, input logic [11:0] a, input logic p,
                           input logic [31:0] exp);
    logic [31:0] d;
    busRead(a, p, d);
    check(req, d, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R11: reset state
    readCheck("R11 raw", 12'h008, 1'b1, 32'h0);
    readCheck("R11 enable", 12'h010, 1'b1, 32'h0);
    readCheck("R11 route", 12'h00C, 1'b1, 32'h0);
    readCheck("R11 soft", 12'h018, 1'b1, 32'h0);
    readCheck("R11 prot", 12'h020, 1'b1, 32'h0);
    readCheck("R11 defvec", 12'h034, 1'b1, 32'h0);
    readCheck("R11 slot addr", 12'h100, 1'b1, 32'h0);
    readCheck("R11 slot ctrl", 12'h23C, 1'b1, 32'h0);
    check("R11 lines", {30'b0, fastIrq, normIrq}, 32'h0);

    // table walk
    hwIrq = 32'h0000_00F0;
    for (int i = 0; i < 17; i++) begin
      if (STEPS[i].wr) busWrite(STEPS[i].addr, STEPS[i].val, 1'b1);
      else readCheck($sformatf("R%0d step %0d", STEPS[i].req, i), STEPS[i].addr, 1'b1,
                     STEPS[i].val);
    end

    // R4: line outputs follow status
    #1 check("R4 fast line", {31'b0, fastIrq}, 32'h1);
    check("R4 norm line", {31'b0, normIrq}, 32'h1);
    busWrite(12'h00C, 32'h0, 1'b1);
    #1 check("R4 fast line off", {31'b0, fastIrq}, 32'h0);
    check("R4 norm line on", {31'b0, normIrq}, 32'h1);

    // vectoring (R9, R10) from a fresh reset
    @(negedge clk); rstN = 1'b0; hwIrq = '0;
    @(negedge clk); rstN = 1'b1;
    busWrite(12'h010, 32'hFFFF_FFFF, 1'b1);
    busWrite(12'h200, 32'h0000_002C, 1'b1);   // slot0 src12 enabled
    busWrite(12'h100, 32'h0000_0100, 1'b1);
    busWrite(12'h208, 32'h0000_0025, 1'b1);   // slot2 src5 enabled
    busWrite(12'h108, 32'h2000_0002, 1'b1);
    busWrite(12'h21C, 32'h0000_0009, 1'b1);   // slot7 src9 disabled
    busWrite(12'h11C, 32'h0000_7000, 1'b1);
    busWrite(12'h034, 32'h0000_D0D0, 1'b1);
    hwIrq = 32'h0000_0220;
    readCheck("R9 slot ctrl readback", 12'h208, 1'b1, 32'h25);
    readCheck("R9 slot addr readback", 12'h108, 1'b1, 32'h2000_0002);
    readCheck("R9 first match", 12'h030, 1'b1, 32'h2000_0002);
    readCheck("R10 same level blocked", 12'h030, 1'b1, 32'h0000_D0D0);
    hwIrq = 32'h0000_1220;
    readCheck("R10 higher preempts", 12'h030, 1'b1, 32'h0000_0100);
    readCheck("R10 all blocked", 12'h030, 1'b1, 32'h0000_D0D0);
    hwIrq = 32'h0000_0220;
    busWrite(12'h030, 32'h0, 1'b1);
    readCheck("R10 lower still in service", 12'h030, 1'b1, 32'h0000_D0D0);
    busWrite(12'h030, 32'h0, 1'b1);
    readCheck("R10 released", 12'h030, 1'b1, 32'h2000_0002);
    busWrite(12'h030, 32'h0, 1'b1);
    busWrite(12'h00C, 32'h0000_0020, 1'b1);
    readCheck("R9 fast source not vectored", 12'h030, 1'b1, 32'h0000_D0D0);
    #1 check("R4 fast line from src5", {31'b0, fastIrq}, 32'h1);

    // R7: protection
    busWrite(12'h020, 32'h1, 1'b1);
    busWrite(12'h010, 32'h0, 1'b0);
    readCheck("R7 refused write", 12'h010, 1'b1, 32'hFFFF_FFFF);
    readCheck("R7 refused read", 12'h010, 1'b0, 32'h0);
    busWrite(12'h020, 32'h0, 1'b0);
    readCheck("R7 prot held", 12'h020, 1'b1, 32'h1);
    busWrite(12'h020, 32'h0, 1'b1);
    readCheck("R7 open read", 12'h010, 1'b0, 32'hFFFF_FFFF);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule